// File: doc/BRIEF.md
# Receive Holding Buffer with Line-Break Insertion

This block sits between a serial deserializer and a bus read port on the receive side of a UART. It holds up to four received bytes and hands them to the bus oldest-first, one per pop. It keeps a ready flag (at least one byte held) and a full flag (every slot taken). It also tells the deserializer through an accept signal whether a new byte would be taken in the current cycle.

A line-break event from the deserializer does two things. It stores a zero byte as if it had been received, and it sets a sticky break flag that stays set until software clears it. A break is never lost. When the buffer is already full and no pop happens in the same cycle, the zero overwrites the newest byte held, and the byte count does not change. The receiver has an enable that is set and cleared by command strobes. A flush empties the buffer and turns the enable off in a single cycle.

Top module: `rx_hold_buf`

## Requirements
- R1: After reset the buffer is empty, `rx_rdy`, `rx_full`, `brk_flag` and `rx_accept` are 0, and `rd_data` reads 0x00.
- R2: Bytes leave in the order they were stored. `rd_data` always shows the oldest held byte, and a pop removes it at the next clock edge.
- R3: While the buffer is empty, `rd_data` is 0x00 and a pop changes no state.
- R4: Any stored byte, whether data or break, makes `rx_rdy` 1 after the next edge. A store that brings the count to four makes `rx_full` 1.
- R5: A pop without a simultaneous break always leaves `rx_full` at 0. A pop that leaves the count at zero drops `rx_rdy` to 0.
- R6: `rx_accept` is 1 exactly when the receiver is enabled and `rx_full` is 0. A `rx_valid` byte offered while `rx_accept` is 0 is discarded.
- R7: A `brk_evt` stores the byte 0x00 whether or not the receiver is enabled. When `brk_evt` and `rx_valid` arrive in the same cycle, the break is stored and the data byte is discarded.
- R8: A break while the buffer is full and no pop is made replaces the most recently stored byte with 0x00. The count stays at four and `rx_full` stays 1.
- R9: A store and a pop in the same cycle remove the oldest byte, append the new byte behind the others, and leave the count unchanged.
- R10: `brk_flag` is set by `brk_evt` and held until `brk_clr`. If both arrive in one cycle, the flag ends up set.
- R11: `flush` empties the buffer, clears `rx_rdy` and `rx_full`, and disables the receiver. It overrides any store or pop in the same cycle and leaves `brk_flag` unchanged.
- R12: `rx_on` enables the receiver and `rx_off` disables it. If both arrive in one cycle, or if `rx_on` arrives together with `flush`, the receiver ends up disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Deserializer offers a byte this cycle |
| rx_data | input | 8 | Byte offered by the deserializer |
| brk_evt | input | 1 | Line-break event strobe |
| rx_on | input | 1 | Receiver enable command strobe |
| rx_off | input | 1 | Receiver disable command strobe |
| flush | input | 1 | Receiver reset: empty buffer, disable |
| brk_clr | input | 1 | Clear strobe for the break flag |
| pop | input | 1 | Bus read removing the oldest byte |
| rd_data | output | 8 | Oldest held byte, or 0x00 when empty |
| rx_rdy | output | 1 | At least one byte is held |
| rx_full | output | 1 | All four slots are held |
| brk_flag | output | 1 | Sticky break-change flag |
| rx_accept | output | 1 | A byte offered now would be stored |

## Verification
The assertions assume that every input is a single-cycle strobe sampled at the rising edge. They also assume that `rx_data` is stable whenever `rx_valid` is high. They place no limit on which strobes may coincide, so a break, pop, flush and enable command may all land in the same cycle. The stimulus first runs directed sequences that create each such collision on purpose: a break against a full buffer, a store together with a pop, a break together with its clear, and a flush together with a store. It then drives a long random run in which every strobe is chosen independently each cycle, with flush kept rare so the buffer regularly fills. A queue-based model is compared with every output after every edge.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

   // Source of the byte written into the buffer in a given cycle.
   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_DATA  = 2'd1,
      SRC_BREAK = 2'd2
   } rxb_src_e;

   function automatic logic src_stores(input rxb_src_e s);
      return s != SRC_NONE;
   endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [DATA_W-1:0]        rd_word
);
   localparam int PTR_W  = $clog2(DEPTH);
   localparam int FLAT_W = DATA_W * DEPTH;

   logic [FLAT_W-1:0] flat;

   // One register per slot, written only when addressed.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == PTR_W'(i))) begin
            word_q <= wr_data;
         end
      end
      assign flat[i*DATA_W +: DATA_W] = word_q;
   end

   assign rd_word = flat[rd_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/rxb_ptr_ctrl.sv
module rxb_ptr_ctrl #(
   parameter int DEPTH = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic                     pop,
   input  logic                     flush,
   output logic                     wr_en,
   output logic [$clog2(DEPTH)-1:0] wr_idx,
   output logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic                     nonempty,
   output logic                     full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   logic [PTR_W-1:0] rd_q, wr_q;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             do_pop, ovr, adv;

   always_comb begin
      nonempty = (cnt_q != '0);
      full     = (cnt_q == CNT_W'(DEPTH));
      do_pop   = pop && nonempty;
      // A store into a full buffer with no pop overwrites the newest slot.
      ovr      = push && full && !do_pop;
      adv      = push && !ovr;
      wr_idx   = ovr ? (wr_q - PTR_W'(1)) : wr_q;
      wr_en    = push && !flush;
      rd_idx   = rd_q;
      cnt_d    = cnt_q + CNT_W'(adv) - CNT_W'(do_pop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_pop) rd_q <= rd_q + PTR_W'(1);
         if (adv)    wr_q <= wr_q + PTR_W'(1);
         cnt_q <= cnt_d;
      end
   end

endmodule

// File: rtl/rxb_status.sv
module rxb_status (
   input  logic clk,
   input  logic rst_n,
   input  logic en_set,
   input  logic en_clr,
   input  logic brk_set,
   input  logic brk_clr,
   output logic enabled,
   output logic brk_flag
);
   logic en_q, brk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         brk_q <= 1'b0;
      end else begin
         // Disable dominates enable.
         if (en_clr)      en_q <= 1'b0;
         else if (en_set) en_q <= 1'b1;
         // Set dominates clear.
         if (brk_set)      brk_q <= 1'b1;
         else if (brk_clr) brk_q <= 1'b0;
      end
   end

   assign enabled  = en_q;
   assign brk_flag = brk_q;

endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
   parameter int          DATA_W     = 8,
   parameter int          DEPTH      = 4,
   parameter logic [DATA_W-1:0] EMPTY_FILL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              brk_evt,
   input  logic              rx_on,
   input  logic              rx_off,
   input  logic              flush,
   input  logic              brk_clr,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_rdy,
   output logic              rx_full,
   output logic              brk_flag,
   output logic              rx_accept
);
   import rxb_pkg::*;

   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rx_hold_buf: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rx_hold_buf: DATA_W must be positive");
   end

   rxb_src_e          src;
   logic              push, wr_en, enabled, nonempty, full;
   logic [PTR_W-1:0]  wr_idx, rd_idx;
   logic [DATA_W-1:0] wr_data, head;

   assign rx_accept = enabled && !full;

   always_comb begin
      if (brk_evt)                    src = SRC_BREAK;
      else if (rx_valid && rx_accept) src = SRC_DATA;
      else                            src = SRC_NONE;
      push    = src_stores(src);
      wr_data = (src == SRC_BREAK) ? '0 : rx_data;
   end

   rxb_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .pop      (pop),
      .flush    (flush),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .rd_idx   (rd_idx),
      .nonempty (nonempty),
      .full     (full)
   );

   rxb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_word (head)
   );

   rxb_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_set   (rx_on),
      .en_clr   (rx_off || flush),
      .brk_set  (brk_evt),
      .brk_clr  (brk_clr),
      .enabled  (enabled),
      .brk_flag (brk_flag)
   );

   assign rd_data = nonempty ? head : EMPTY_FILL;
   assign rx_rdy  = nonempty;
   assign rx_full = full;

endmodule

// File: rtl/rx_hold_buf_chk.sv
module rx_hold_buf_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_data,
   input logic              brk_evt,
   input logic              rx_on,
   input logic              rx_off,
   input logic              flush,
   input logic              brk_clr,
   input logic              pop,
   input logic [DATA_W-1:0] rd_data,
   input logic              rx_rdy,
   input logic              rx_full,
   input logic              brk_flag,
   input logic              rx_accept
);
   a_r2_first_byte_at_head: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_rdy && rx_valid && rx_accept && !brk_evt && !flush) |=> (rd_data == $past(rx_data)));

   a_r3_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_rdy |-> (rd_data == '0));

   a_r4_store_sets_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      ((brk_evt || (rx_valid && rx_accept)) && !flush) |=> rx_rdy);

   a_r5_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && rx_full && !brk_evt && !flush) |=> !rx_full);

   a_r6_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> !rx_accept);

   a_r8_break_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && brk_evt && !pop && !flush) |=> (rx_full && rd_data == $past(rd_data)));

   a_r9_push_pop_same_level: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rdy && pop && rx_valid && rx_accept && !brk_evt && !flush) |=> (rx_rdy && $stable(rx_full)));

   a_r10_break_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt |=> brk_flag);

   a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_flag && !brk_clr) |=> brk_flag);

   a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!rx_rdy && !rx_full && !rx_accept));

   a_r12_off_disables: assert property (@(posedge clk) disable iff (!rst_n)
      rx_off |=> !rx_accept);

   a_r12_on_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_on && !rx_off && !flush && !rx_full && !rx_valid && !brk_evt) |=> rx_accept);

endmodule

bind rx_hold_buf rx_hold_buf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rx_hold_buf_bench.sv
module rx_hold_buf_bench;
   localparam int CLK_P = 10;
   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rx_valid, brk_evt, rx_on, rx_off, flush, brk_clr, pop;
   logic [7:0] rx_data;
   logic [7:0] rd_data;
   logic       rx_rdy, rx_full, brk_flag, rx_accept;

   int checks = 0;
   int fails  = 0;

   // Reference model state
   byte unsigned m_q[$];
   bit           m_en;
   bit           m_brk;

   always #(CLK_P/2) clk = ~clk;

   rx_hold_buf u_rx_hold_buf (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .brk_evt(brk_evt), .rx_on(rx_on), .rx_off(rx_off), .flush(flush),
      .brk_clr(brk_clr), .pop(pop), .rd_data(rd_data), .rx_rdy(rx_rdy),
      .rx_full(rx_full), .brk_flag(brk_flag), .rx_accept(rx_accept)
   );

   task automatic cmp(input string tag, input string fld, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, fld, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string tag);
      cmp(tag, "rd_data(R2)", int'(rd_data), (m_q.size() > 0) ? int'(m_q[0]) : 0);
      cmp(tag, "rx_rdy(R4)", int'(rx_rdy), int'(m_q.size() > 0));
      cmp(tag, "rx_full(R5)", int'(rx_full), int'(m_q.size() == DEPTH));
      cmp(tag, "rx_accept(R6)", int'(rx_accept), int'(m_en && m_q.size() < DEPTH));
      cmp(tag, "brk_flag(R10)", int'(brk_flag), int'(m_brk));
   endtask

   // One clock: drive at the falling edge, update the model at the rising
   // edge, compare at the next falling edge.
   task automatic step(input bit v, input byte unsigned d, input bit b, input bit on,
                       input bit off, input bit fl, input bit bc, input bit p,
                       input string tag);
      bit acc;
      bit st;
      byte unsigned sb;
      rx_valid = v; rx_data = d; brk_evt = b; rx_on = on; rx_off = off;
      flush = fl; brk_clr = bc; pop = p;
      @(posedge clk);
      acc = m_en && (m_q.size() < DEPTH);
      st  = b || (v && acc);
      sb  = b ? 8'h00 : d;
      if (fl) begin
         m_q.delete();
      end else begin
         if (p && m_q.size() > 0) void'(m_q.pop_front());
         if (st) begin
            if (m_q.size() == DEPTH) m_q[DEPTH-1] = sb;
            else m_q.push_back(sb);
         end
      end
      if (fl || off) m_en = 1'b0;
      else if (on)   m_en = 1'b1;
      if (b)       m_brk = 1'b1;
      else if (bc) m_brk = 1'b0;
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic idle(input string tag);
      step(0, 8'h00, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      rst_n = 1'b0;
      rx_valid = 0; rx_data = 0; brk_evt = 0; rx_on = 0; rx_off = 0;
      flush = 0; brk_clr = 0; pop = 0;
      m_en = 0; m_brk = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      compare_all("R1");

      // R6: disabled receiver refuses data
      step(1, 8'hA5, 0, 0, 0, 0, 0, 0, "R6");
      cmp("R6", "rx_rdy after refused byte", int'(rx_rdy), 0);

      // R12: enable
      step(0, 8'h00, 0, 1, 0, 0, 0, 0, "R12");
      cmp("R12", "rx_accept after rx_on", int'(rx_accept), 1);

      // R2: ordering
      step(1, 8'h11, 0, 0, 0, 0, 0, 0, "R2");
      step(1, 8'h22, 0, 0, 0, 0, 0, 0, "R2");
      step(1, 8'h33, 0, 0, 0, 0, 0, 0, "R2");
      cmp("R2", "head byte", int'(rd_data), 'h11);
      step(0, 8'h00, 0, 0, 0, 0, 0, 1, "R2");
      step(0, 8'h00, 0, 0, 0, 0, 0, 1, "R2");
      cmp("R2", "third byte", int'(rd_data), 'h33);
      step(0, 8'h00, 0, 0, 0, 0, 0, 1, "R5");
      cmp("R5", "rx_rdy after last pop", int'(rx_rdy), 0);

      // R3: pop on empty
      step(0, 8'h00, 0, 0, 0, 0, 0, 1, "R3");
      cmp("R3", "rd_data empty", int'(rd_data), 0);

      // R4: fill to four
      for (int i = 0; i < DEPTH; i++) step(1, byte'(8'h40 + i), 0, 0, 0, 0, 0, 0, "R4");
      cmp("R4", "rx_full at four", int'(rx_full), 1);
      // R6: byte offered while full is dropped
      step(1, 8'hEE, 0, 0, 0, 0, 0, 0, "R6");

      // R8: break while full overwrites newest
      step(0, 8'h00, 1, 0, 0, 0, 0, 0, "R8");
      cmp("R8", "rx_full after break", int'(rx_full), 1);
      for (int i = 0; i < DEPTH - 1; i++) step(0, 8'h00, 0, 0, 0, 0, 0, 1, "R8");
      cmp("R8", "newest replaced by zero", int'(rd_data), 0);
      cmp("R8", "one byte left", int'(rx_rdy), 1);
      step(0, 8'h00, 0, 0, 0, 0, 0, 1, "R5");

      // R9: simultaneous store and pop
      step(1, 8'h51, 0, 0, 0, 0, 0, 0, "R9");
      step(1, 8'h52, 0, 0, 0, 0, 0, 0, "R9");
      step(1, 8'h53, 0, 0, 0, 0, 0, 1, "R9");
      cmp("R9", "head after push+pop", int'(rd_data), 'h52);
      step(0, 8'h00, 0, 0, 0, 0, 0, 1, "R9");
      cmp("R9", "appended byte", int'(rd_data), 'h53);

      // R10: clear flag, then simultaneous set and clear
      step(0, 8'h00, 0, 0, 0, 0, 1, 0, "R10");
      cmp("R10", "flag cleared", int'(brk_flag), 0);
      step(0, 8'h00, 1, 0, 0, 0, 1, 0, "R10");
      cmp("R10", "set wins", int'(brk_flag), 1);

      // R7: break together with data; break wins
      step(1, 8'h99, 1, 0, 0, 0, 0, 0, "R7");
      idle("R7");

      // R11: flush with a store in the same cycle
      step(1, 8'h77, 0, 0, 0, 1, 0, 0, "R11");
      cmp("R11", "empty after flush", int'(rx_rdy), 0);
      cmp("R11", "disabled after flush", int'(rx_accept), 0);
      cmp("R11", "break flag kept", int'(brk_flag), 1);

      // R12: on with off, and on with flush
      step(0, 8'h00, 0, 1, 1, 0, 0, 0, "R12");
      cmp("R12", "off wins", int'(rx_accept), 0);
      step(0, 8'h00, 0, 1, 0, 1, 0, 0, "R12");
      cmp("R12", "flush wins", int'(rx_accept), 0);
      // R7: break stored while disabled
      step(0, 8'h00, 1, 0, 0, 0, 0, 0, "R7");
      cmp("R7", "break stored while disabled", int'(rx_rdy), 1);

      // Random run
      for (int n = 0; n < 3000; n++) begin
         step(($urandom % 3) != 0, byte'($urandom), ($urandom % 13) == 0,
              ($urandom % 6) == 0, ($urandom % 17) == 0, ($urandom % 41) == 0,
              ($urandom % 9) == 0, ($urandom % 3) == 0, "RND");
      end

      summary();
   end

endmodule